// File: doc/BRIEF.md
# Sigma-Delta Conversion Rate Timer

This block paces a decimating sigma-delta converter. A fast reference clock drives a period counter. A 3-bit rate code selects a decimation ratio, and each conversion period lasts a fixed multiplier times that ratio in reference cycles. The multiplier is 448 by default. The block raises a one-cycle period tick at the end of every period.

The block also tracks how many periods have passed since the decimation filter was last restarted. Its data-ready pulse fires only once the filter output can be trusted, which takes four periods after a start. In continuous mode a result is then ready at the end of every period. In single mode the block delivers one result and returns to idle, so results come out at a quarter of the continuous rate.

A rate-code change waits for the current period to finish and then forces a fresh settling phase. Clearing the enable halts everything. A start request (re)launches the counters from zero.

Top module: `conv_rate_timer`

## Requirements
- R1: Rate codes 0,1,2,3,4,5,6,7 select decimation ratios 1096, 274, 220, 183, 55, 46, 27, 23. A period lasts P = PERIOD_MUL × ratio cycles.
- R2: After reset, `busy`, `period_tick` and `data_ready` are low. They stay low until a start is sampled while `en` is high.
- R3: When `start` is sampled high with `en` high, `busy` rises. The first `period_tick` is high during the P-th cycle after that edge (index P-1, with index 0 being the cycle just after the edge).
- R4: The first `data_ready` after a start comes at the end of the fourth period, at index 4·P-1.
- R5: In continuous mode (`cont`=1), once settled, `data_ready` repeats every P cycles.
- R6: In single mode (`cont`=0), after its one `data_ready` the block drops `busy` on the next cycle and issues no further ticks until a new start.
- R7: A start sampled while running restarts both the period count and the settling count from zero.
- R8: A new rate code is taken only at a period boundary. The period in progress keeps its old length and still reports its result if settled. The new code then needs four of its own periods before the next `data_ready`.
- R9: With `en` low the block is idle: `busy` falls the next cycle, and starts are ignored.
- R10: `data_ready` is a one-cycle pulse and is only ever high together with `period_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| start | input | 1 | Start / filter-reset request |
| cont | input | 1 | 1 = continuous conversions, 0 = single conversion |
| rate | input | 3 | Rate code |
| period_tick | output | 1 | High in the last cycle of each period |
| data_ready | output | 1 | One-cycle pulse when a valid result is available |
| busy | output | 1 | Conversion sequence in progress |

## Verification
The bench builds the timer with PERIOD_MUL = 2 and the default settling depth of four. This keeps even the slowest code at 2192 cycles per period. With these values, every rate code's period length, four-period settling, and repeated random sequences of continuous and single runs all fit in one short run. It also puts mid-period restarts and rate changes within reach. The ratio table and the settling arithmetic are the same as with the full 448 multiplier. Only the multiplier scales.

// File: rtl/conv_rate_timer.sv
module conv_rate_timer #(
  parameter int PERIOD_MUL = 448,
  parameter int SETTLE     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       start,
  input  logic       cont,
  input  logic [2:0] rate,
  output logic       period_tick,
  output logic       data_ready,
  output logic       busy
);
  localparam int CW = $clog2(PERIOD_MUL * 1096 + 1);
  localparam int SW = $clog2(SETTLE + 1);

  function automatic int dec_ratio(input logic [2:0] c);
    case (c)
      3'd0: return 1096;
      3'd1: return 274;
      3'd2: return 220;
      3'd3: return 183;
      3'd4: return 55;
      3'd5: return 46;
      3'd6: return 27;
      default: return 23;
    endcase
  endfunction

  logic [2:0]    act_rate;
  logic [CW-1:0] cnt;
  logic [SW-1:0] settle;
  logic [CW-1:0] last;

  assign last        = CW'(PERIOD_MUL * dec_ratio(act_rate) - 1);
  assign period_tick = busy && (cnt == last);
  assign data_ready  = period_tick && (settle >= SW'(SETTLE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      settle   <= '0;
      act_rate <= '0;
    end else if (!en) begin
      busy   <= 1'b0;
      cnt    <= '0;
      settle <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= '0;
      settle   <= '0;
      act_rate <= rate;
    end else if (busy) begin
      if (period_tick) begin
        cnt <= '0;
        if (rate != act_rate) begin
          act_rate <= rate;
          settle   <= '0;
        end else if (settle != SW'(SETTLE)) begin
          settle <= settle + SW'(1);
        end
        if (data_ready && !cont) busy <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

module conv_rate_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic start,
  input logic cont,
  input logic period_tick,
  input logic data_ready,
  input logic busy
);
  a_r10_ready_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> period_tick);
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> !data_ready);
  a_r2_tick_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |-> busy);
  a_r9_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(en && start) |=> !busy);
  a_r6_single_stops: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready && !cont && !start |=> !busy);
endmodule

bind conv_rate_timer conv_rate_timer_chk u_chk (.*);

// File: tb/conv_rate_timer_test.sv
module conv_rate_timer_test;
  localparam int MUL = 2;
  localparam int LIM = 20000;

  logic clk = 0, rst_n = 0, en = 0, start = 0, cont = 0;
  logic [2:0] rate = 0;
  logic period_tick, data_ready, busy;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  conv_rate_timer #(.PERIOD_MUL(MUL)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .cont(cont),
    .rate(rate), .period_tick(period_tick), .data_ready(data_ready), .busy(busy));

  function automatic int plen(input logic [2:0] c);
    int r;
    case (c)
      0: r = 1096; 1: r = 274; 2: r = 220; 3: r = 183;
      4: r = 55;   5: r = 46;  6: r = 27;  default: r = 23;
    endcase
    return MUL * r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_evt(input bit rdy, output int d);
    d = 0;
    do begin @(negedge clk); d++; end
    while (!(rdy ? data_ready : period_tick) && d < LIM);
  endtask

  task automatic do_start(input logic [2:0] c, input logic m);
    rate = c; cont = m; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic quiet(input int n, output int ticks);
    ticks = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); ticks += period_tick; end
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int d, t;
    logic [2:0] c;
    logic m;
    void'($urandom(32'd1234));
    @(negedge clk);
    chk("R2 reset busy", busy, 0);
    chk("R2 reset tick", period_tick, 0);
    chk("R2 reset ready", data_ready, 0);
    rst_n = 1;
    start = 1; @(negedge clk); start = 0;
    quiet(60, t);
    chk("R9 start without en ignored", busy + t, 0);
    en = 1;
    quiet(60, t);
    chk("R2 enabled but no start", busy + t, 0);

    for (int k = 0; k < 8; k++) begin
      do_start(3'(k), 1);
      chk("R3 busy after start", busy, 1);
      next_evt(0, d);
      chk($sformatf("R1 R3 first tick code %0d", k), d, plen(3'(k)) - 1);
    end

    do_start(3'd6, 1);
    next_evt(1, d); chk("R4 first ready", d, 4 * plen(6) - 1);
    next_evt(1, d); chk("R5 cont repeat", d, plen(6));
    next_evt(1, d); chk("R5 cont repeat again", d, plen(6));

    repeat (10) @(negedge clk);
    rate = 3'd4;
    next_evt(1, d); chk("R8 old period finishes", d, plen(6) - 10);
    next_evt(1, d); chk("R8 new code resettles", d, 4 * plen(4));

    repeat (30) @(negedge clk);
    do_start(3'd4, 1);
    next_evt(1, d); chk("R7 restart mid-run", d, 4 * plen(4) - 1);

    do_start(3'd7, 0);
    next_evt(1, d); chk("R6 single ready", d, 4 * plen(7) - 1);
    @(negedge clk);
    chk("R6 busy drops", busy, 0);
    quiet(200, t); chk("R6 no ticks after single", t, 0);

    do_start(3'd5, 1);
    next_evt(0, d);
    chk("R10 ready absent before settled", data_ready, 0);
    repeat (5) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk("R9 disable drops busy", busy, 0);
    quiet(200, t); chk("R9 disabled no ticks", t, 0);
    en = 1;

    for (int k = 0; k < 8; k++) begin
      c = 3'($urandom_range(1, 7));
      m = 1'($urandom_range(0, 1));
      do_start(c, m);
      next_evt(1, d); chk("R4 random first ready", d, 4 * plen(c) - 1);
      @(negedge clk);
      chk("R10 ready one cycle", data_ready, 0);
      if (m) begin
        next_evt(1, d); chk("R5 random cont repeat", d, plen(c) - 1);
      end else begin
        chk("R6 random single idle", busy, 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule